// File: doc/BRIEF.md
# Integer ALU with NZCV Status and Branch Compare

This block is a purely combinational 32-bit integer arithmetic and logic unit. It takes two operand words and a 3-bit operation select. It returns a result word and a 4-bit status vector made of the negative, zero, carry and overflow flags. The unit adds and subtracts; addition also serves base-plus-offset address generation. It also performs four bitwise operations, a signed set-on-less-than, and a pass-through of the second operand.

Beside the main datapath, a small compare unit always subtracts the second operand from the first. From the zero flag of that difference it drives a branch-if-equal and a branch-if-not-equal decision. Set-on-less-than takes its answer from the sign and overflow of the same kind of subtraction, so the block has no magnitude comparator. There are no clocks or registers: every output settles from the inputs alone.

Top module: `alu_nzcv`

## Requirements
- R1: With op_sel = 3'b000 (add), result equals op_a + op_b modulo 2^32; with op_b holding an offset such as 4 this gives base plus offset.
- R2: With op_sel = 3'b001 (subtract), result equals op_a - op_b modulo 2^32, formed as op_a plus the inverted op_b with a carry-in of 1.
- R3: status[1] (C) is the carry out of bit 31 of the adder for add and subtract, so for subtract it is 1 exactly when no borrow occurs (op_a >= op_b unsigned).
- R4: status[0] (V) is 1 for add or subtract exactly when the signed two's-complement result does not fit in 32 bits.
- R5: For every operation status[3] (N) equals result[31], and status[2] (Z) is 1 exactly when all 32 result bits are 0.
- R6: op_sel 3'b010 gives op_a AND op_b, 3'b011 gives OR, 3'b100 gives XOR, 3'b101 gives NOR, and 3'b111 passes op_b through. For these operations, and for 3'b110, C and V are 0.
- R7: With op_sel = 3'b110 (set-on-less-than), result is 1 when op_a < op_b as signed numbers and 0 otherwise, with bits 31:1 always 0. The decision stays correct when op_a - op_b overflows.
- R8: br_eq is 1 and br_ne is 0 exactly when op_a equals op_b, whatever op_sel holds; otherwise br_eq is 0 and br_ne is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 32 | First operand (base for address generation) |
| op_b | input | 32 | Second operand (offset for address generation) |
| op_sel | input | 3 | Operation select |
| result | output | 32 | Result word |
| status | output | 4 | Flags: [3] N, [2] Z, [1] C, [0] V |
| br_eq | output | 1 | Branch-if-equal decision from op_a - op_b |
| br_ne | output | 1 | Branch-if-not-equal decision from op_a - op_b |

## Verification
Random operand pairs over all eight operation codes exercise the result mux and show that each code selects its own function. Directed pairs place the adder at its edges: all-ones plus one separates carry from overflow, the largest positive plus one separates overflow from carry, and equal or reversed operands in subtraction separate no-borrow from borrow. Set-on-less-than pairs chosen so that the subtraction overflows tell an N-only decision apart from the N XOR V decision. Equal and unequal operand pairs under non-subtract codes show that the branch outputs do not depend on the selected operation.

// File: rtl/alu_nzcv_pkg.sv
package alu_nzcv_pkg;

    localparam int DATA_W = 32;
    localparam int SEL_W  = 3;

    typedef enum logic [SEL_W-1:0] {
        OP_ADD  = 3'b000,
        OP_SUB  = 3'b001,
        OP_AND  = 3'b010,
        OP_OR   = 3'b011,
        OP_XOR  = 3'b100,
        OP_NOR  = 3'b101,
        OP_SLT  = 3'b110,
        OP_PASS = 3'b111
    } alu_op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } nzcv_t;

    function automatic logic uses_adder_flags(alu_op_e op);
        return (op == OP_ADD) || (op == OP_SUB);
    endfunction

    function automatic logic is_bitwise(alu_op_e op);
        return (op == OP_AND) || (op == OP_OR) || (op == OP_XOR) ||
               (op == OP_NOR) || (op == OP_PASS);
    endfunction

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         ovf
);
    logic [W-1:0] b_eff;
    logic [W:0]   wide;

    always_comb begin
        b_eff = sub ? ~b : b;
        wide  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, sub};
        sum   = wide[W-1:0];
        cout  = wide[W];
        // same effective input sign, opposite result sign
        ovf   = (a[W-1] == b_eff[W-1]) && (wide[W-1] != a[W-1]);
    end
endmodule

// File: rtl/alu_bitwise.sv
module alu_bitwise
    import alu_nzcv_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_op_e      op,
    output logic [W-1:0] y
);
    always_comb begin
        unique case (op)
            OP_AND:  y = a & b;
            OP_OR:   y = a | b;
            OP_XOR:  y = a ^ b;
            OP_NOR:  y = ~(a | b);
            OP_PASS: y = b;
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/alu_branch_cmp.sv
module alu_branch_cmp #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         take_eq,
    output logic         take_ne
);
    logic [W-1:0] diff;
    logic         unused_c;
    logic         unused_v;
    logic         diff_zero;

    alu_addsub #(.W(W)) u_cmp_sub (
        .a    (a),
        .b    (b),
        .sub  (1'b1),
        .sum  (diff),
        .cout (unused_c),
        .ovf  (unused_v)
    );

    always_comb begin
        diff_zero = ~|diff;
        take_eq   = diff_zero;
        take_ne   = ~diff_zero;
    end
endmodule

// File: rtl/alu_nzcv.sv
module alu_nzcv
    import alu_nzcv_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [W-1:0]     op_a,
    input  logic [W-1:0]     op_b,
    input  logic [SEL_W-1:0] op_sel,
    output logic [W-1:0]     result,
    output logic [3:0]       status,
    output logic             br_eq,
    output logic             br_ne
);
    alu_op_e      op;
    logic [W-1:0] arith_y;
    logic         arith_c;
    logic         arith_v;
    logic [W-1:0] logic_y;
    logic         less;
    nzcv_t        flags;

    assign op = alu_op_e'(op_sel);

    // add for OP_ADD, subtract for everything else (SUB and SLT need it)
    alu_addsub #(.W(W)) u_addsub (
        .a    (op_a),
        .b    (op_b),
        .sub  (op != OP_ADD),
        .sum  (arith_y),
        .cout (arith_c),
        .ovf  (arith_v)
    );

    alu_bitwise #(.W(W)) u_bitwise (
        .a  (op_a),
        .b  (op_b),
        .op (op),
        .y  (logic_y)
    );

    alu_branch_cmp #(.W(W)) u_branch (
        .a       (op_a),
        .b       (op_b),
        .take_eq (br_eq),
        .take_ne (br_ne)
    );

    always_comb begin
        less = arith_y[W-1] ^ arith_v;
        if (uses_adder_flags(op)) begin
            result = arith_y;
        end else if (op == OP_SLT) begin
            result = {{(W-1){1'b0}}, less};
        end else if (is_bitwise(op)) begin
            result = logic_y;
        end else begin
            result = '0;
        end

        flags.n = result[W-1];
        flags.z = ~|result;
        flags.c = uses_adder_flags(op) ? arith_c : 1'b0;
        flags.v = uses_adder_flags(op) ? arith_v : 1'b0;
        status  = flags;
    end
endmodule

// File: rtl/alu_nzcv_chk.sv
module alu_nzcv_chk #(
    parameter int W = 32
) (
    input logic [W-1:0] op_a,
    input logic [W-1:0] op_b,
    input logic [2:0]   op_sel,
    input logic [W-1:0] result,
    input logic [3:0]   status,
    input logic         br_eq,
    input logic         br_ne
);
    logic known;
    assign known = !$isunknown({op_a, op_b, op_sel, result, status, br_eq, br_ne});

    always_comb begin
        if (known) begin
            if (op_sel == 3'b000)
                a_r1_add_sum: assert (result == op_a + op_b);
            a_r5_zero_flag: assert (status[2] == (result == '0));
            a_r5_neg_flag: assert (status[3] == result[W-1]);
            if (op_sel[2] || op_sel[1])
                a_r6_no_cv: assert (status[1:0] == 2'b00);
            if (op_sel == 3'b110)
                a_r7_slt_upper: assert (result[W-1:1] == '0);
            a_r8_branch: assert ((br_eq == (op_a == op_b)) && (br_ne != br_eq));
        end
    end
endmodule

bind alu_nzcv alu_nzcv_chk #(.W(W)) u_chk (
    .op_a   (op_a),
    .op_b   (op_b),
    .op_sel (op_sel),
    .result (result),
    .status (status),
    .br_eq  (br_eq),
    .br_ne  (br_ne)
);

// File: tb/alu_nzcv_test.sv
module alu_nzcv_test;

    logic        clk = 1'b0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic [2:0]  op_sel = '0;
    logic [31:0] result;
    logic [3:0]  status;
    logic        br_eq;
    logic        br_ne;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    alu_nzcv uut (
        .op_a   (op_a),
        .op_b   (op_b),
        .op_sel (op_sel),
        .result (result),
        .status (status),
        .br_eq  (br_eq),
        .br_ne  (br_ne)
    );

    function automatic logic [31:0] exp_result(logic [31:0] a, logic [31:0] b, logic [2:0] s);
        case (s)
            3'd0: return a + b;
            3'd1: return a - b;
            3'd2: return a & b;
            3'd3: return a | b;
            3'd4: return a ^ b;
            3'd5: return ~(a | b);
            3'd6: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
            default: return b;
        endcase
    endfunction

    function automatic logic exp_carry(logic [31:0] a, logic [31:0] b, logic [2:0] s);
        logic [32:0] t;
        if (s == 3'd0) begin
            t = {1'b0, a} + {1'b0, b};
            return t[32];
        end
        if (s == 3'd1) return a >= b;
        return 1'b0;
    endfunction

    function automatic logic exp_ovf(logic [31:0] a, logic [31:0] b, logic [2:0] s);
        longint sa, sb, r;
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        if (s == 3'd0) r = sa + sb;
        else if (s == 3'd1) r = sa - sb;
        else return 1'b0;
        return (r > 64'sd2147483647) || (r < -64'sd2147483648);
    endfunction

    function automatic string op_tag(logic [2:0] s);
        case (s)
            3'd0: return "R1";
            3'd1: return "R2";
            3'd6: return "R7";
            default: return "R6";
        endcase
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s a=%h b=%h sel=%0d actual=%h expected=%h",
                     tag, op_a, op_b, op_sel, act, exp);
        end
    endtask

    task automatic apply(logic [31:0] a, logic [31:0] b, logic [2:0] s);
        logic [31:0] er;
        @(posedge clk);
        op_a = a;
        op_b = b;
        op_sel = s;
        @(negedge clk);
        er = exp_result(a, b, s);
        check(op_tag(s), result, er);
        check("R5 N", {31'd0, status[3]}, {31'd0, er[31]});
        check("R5 Z", {31'd0, status[2]}, {31'd0, er == 32'd0});
        check((s <= 3'd1) ? "R3 C" : "R6 C", {31'd0, status[1]}, {31'd0, exp_carry(a, b, s)});
        check((s <= 3'd1) ? "R4 V" : "R6 V", {31'd0, status[0]}, {31'd0, exp_ovf(a, b, s)});
        check("R8 eq/ne", {30'd0, br_eq, br_ne}, {30'd0, a == b, a != b});
    endtask

    initial begin
        int unsigned seed;
        seed = 32'h1234_5678;
        void'($urandom(seed));
        // initial inputs: all zero add
        @(negedge clk);
        check("R5 init Z", {28'd0, status}, 32'h4);
        check("R1 init", result, 32'd0);

        apply(32'h1000_0000, 32'd4, 3'd0);              // R1 base + offset
        apply(32'hFFFF_FFFF, 32'd1, 3'd0);              // R3 carry, no overflow
        apply(32'h7FFF_FFFF, 32'd1, 3'd0);              // R4 overflow, no carry
        apply(32'h8000_0000, 32'h8000_0000, 3'd0);      // R3 and R4 both
        apply(32'd25, 32'd25, 3'd1);                    // R2 equal: Z, no borrow
        apply(32'd0, 32'd1, 3'd1);                      // R3 borrow
        apply(32'h8000_0000, 32'd1, 3'd1);              // R4 sub overflow
        apply(32'h8000_0000, 32'd1, 3'd6);              // R7 overflow case -> 1
        apply(32'h7FFF_FFFF, 32'h8000_0000, 3'd6);      // R7 overflow case -> 0
        apply(32'hFFFF_FFFF, 32'd0, 3'd6);              // R7 -1 < 0
        apply(32'd5, 32'd5, 3'd6);                      // R7 equal -> 0
        apply(32'hF0F0_F0F0, 32'h0FF0_0FF0, 3'd5);      // R6 NOR
        apply(32'h0000_0000, 32'h0000_0000, 3'd5);      // R6 NOR all ones -> N
        apply(32'h1234_5678, 32'h1234_5678, 3'd4);      // R6 XOR zero, R8 eq under xor
        apply(32'h1111_1111, 32'h8000_0001, 3'd7);      // R6 pass B
        apply(32'hDEAD_BEEF, 32'hDEAD_BEEF, 3'd2);      // R8 eq under and

        for (int i = 0; i < 3000; i++) begin
            logic [31:0] ra, rb;
            ra = $urandom;
            rb = (i % 7 == 0) ? ra : $urandom;
            if (i % 11 == 0) rb = ra ^ 32'h8000_0000;
            apply(ra, rb, 3'($urandom % 8));
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule